// File: doc/BRIEF.md
# PCI Type-0 Configuration Header with Write Masks

This block holds the 256-byte configuration header of one PCI function as 64 dword registers. Software reaches it through dword-indexed read and write requests, and a byte-enable nibble selects which bytes a write touches. Every byte has a writable mask and a write-one-to-clear mask. A write changes only the writable bits of a byte. Any bit that is written as one and is marked write-one-to-clear is then cleared. Identification fields are loaded from parameters at reset and cannot be changed.

Parameters set the kind and size of each base address register: none, 32-bit memory, 64-bit memory or I/O. The writable mask of a base address register covers only its address bits above the size. Writing all ones therefore reads back the size mask, and the type bits are unchanged. The block decodes every base address register and the expansion ROM register into a 64-bit base and an enable. The memory-space and I/O-space bits of the command register gate these outputs. When the decoded map changes, the block raises a one-cycle pulse so that address routing elsewhere can update.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset the BAR enables and the ROM enable are 0, and the command dword reads 0. BAR dwords read their type bits only: 0x4 for a 64-bit memory BAR, 0x1 for an I/O BAR, and 0 otherwise. Every decoded base reads all ones.
- R2: A read request to dword index A returns that dword on rdata_o one cycle later, with rvalid_o high for exactly that cycle.
- R3: A write changes only the bytes whose byte-enable bit is set, and only the writable bits of those bytes. In dword 1 the writable command bits are 0, 1, 2, 6, 8 and 10. In dword 3, bits 15:0 are writable. In dword 15, bits 7:0 are writable.
- R4: Status bits 31:27 and 24 of dword 1 are write-one-to-clear. status_set_i bits 15:11 and 8 set them. Writing 1 to such a bit clears it, and writing 0 leaves it. For every byte, the writable mask and the write-one-to-clear mask have no bit in common.
- R5: Writing all ones to a BAR reads back ~(size-1) over its address bits, with the type bits kept. Address bits below the size always read 0. The upper dword of a 64-bit BAR is fully writable.
- R6: BAR n sits at dword 4+n, that is byte offset 0x10+4n. Bit 0 of a BAR selects I/O (1) or memory (0). For memory BARs, bits 2:1 equal 2 when the BAR is 64-bit.
- R7: A memory BAR is enabled only while command bit 1 is set. Its base is the BAR dword with bits 3:0 cleared. For a 64-bit BAR, the following dword supplies base bits 63:32.
- R8: An I/O BAR is enabled only while command bit 0 is set. Its base is the BAR dword with bits 1:0 cleared.
- R9: The base output of any BAR that is not enabled, of an absent BAR and of the upper half of a 64-bit BAR is all ones. The same holds for a disabled ROM.
- R10: The expansion ROM register is dword 12 (offset 0x30). Bits 31:11 hold the address above the ROM size, bits 10:1 read 0, and bit 0 is the ROM enable. The ROM decodes as enabled only when bit 0 and command bit 1 are both set.
- R11: map_chg_o pulses for one cycle, in the cycle after a write, when that write changed any decoded base or enable. It stays low when a write leaves the decode unchanged.
- R12: Dword 0 (device and vendor ID), dword 2 (class code and revision) and the header type byte (bits 23:16 of dword 3) keep their parameter values through writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Dword index into the header |
| be_i | input | 4 | Byte enables of a write |
| wdata_i | input | 32 | Write data |
| status_set_i | input | 16 | Sets write-one-to-clear status bits |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| bar_en_o | output | 6 | Per-BAR decoded enable |
| bar_base_o | output | 384 | Per-BAR decoded base, 64 bits each, BAR n at bits 64n+63:64n |
| rom_en_o | output | 1 | Expansion ROM decoded enable |
| rom_base_o | output | 32 | Expansion ROM decoded base |
| map_chg_o | output | 1 | One-cycle pulse when the decoded map changed |

## Verification
The hardest case to reach is a write that leaves the decoded map exactly as it was. A change pulse must not appear then, and that can only be seen after the map has already been brought into a known enabled state. To get there, the stimulus first probes the BARs and programs them while both command enables are off. Every one of those writes must give no pulse. The stimulus then turns on memory space and I/O space in separate steps. Next it rewrites the upper dword of the 64-bit BAR with its current value. It also rewrites the command register together with a status clear that does not affect decoding. Both writes must leave map_chg_o low.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int HDR_DWORDS = 64;
  localparam int HDR_AW     = $clog2(HDR_DWORDS);
  localparam int NUM_BAR    = 6;
  localparam int DW_CMD     = 1;
  localparam int DW_CLASS   = 2;
  localparam int DW_HDR     = 3;
  localparam int DW_BAR0    = 4;
  localparam int DW_ROM     = 12;
  localparam int DW_INT     = 15;
  localparam int CMD_IO_BIT  = 0;
  localparam int CMD_MEM_BIT = 1;

  localparam logic [15:0] CMD_WMASK = 16'h0547;
  localparam logic [15:0] STS_W1C   = 16'hF900;

  typedef enum logic [1:0] {
    BAR_NONE  = 2'd0,
    BAR_MEM32 = 2'd1,
    BAR_MEM64 = 2'd2,
    BAR_IO    = 2'd3
  } bar_kind_e;

  function automatic logic [63:0] size_mask(input int unsigned lg);
    logic [63:0] one;
    one = 64'd1 << lg;
    return ~(one - 64'd1);
  endfunction

  function automatic logic [7:0] byte_update(input logic [7:0] old, input logic [7:0] d,
                                             input logic [7:0] wm, input logic [7:0] w1c);
    logic [7:0] n;
    n = (old & ~wm) | (d & wm);
    return n & ~(d & w1c);
  endfunction
endpackage

// File: rtl/cfg_mask_gen.sv
module cfg_mask_gen
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0]          VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0]          DEVICE_ID  = 16'h0F21,
  parameter logic [7:0]           REV_ID     = 8'h02,
  parameter logic [23:0]          CLASS_CODE = 24'h020000,
  parameter logic [7:0]           INT_PIN    = 8'h01,
  parameter logic [2*NUM_BAR-1:0] BAR_KIND   = 12'h072,
  parameter logic [8*NUM_BAR-1:0] BAR_SZ_LG  = 48'h00000E050011,
  parameter int unsigned          ROM_SZ_LG  = 18
) (
  output logic [HDR_DWORDS-1:0][31:0] wmask_o,
  output logic [HDR_DWORDS-1:0][31:0] w1c_o,
  output logic [HDR_DWORDS-1:0][31:0] init_o
);
  localparam logic [2*NUM_BAR+1:0] KIND_SH = {BAR_KIND, 2'b00};
  localparam logic [63:0] ROM_M = size_mask(ROM_SZ_LG);
  localparam logic [31:0] ROM_WM = (ROM_SZ_LG == 0) ? 32'h0 :
                                   ((ROM_M[31:0] & 32'hFFFF_F800) | 32'h1);

  for (genvar n = 0; n < NUM_BAR; n++) begin : g_bar
    localparam bar_kind_e K  = bar_kind_e'(BAR_KIND[2*n +: 2]);
    localparam bit        UP = (KIND_SH[2*n +: 2] == 2'd2);
    localparam logic [63:0] M  = size_mask(int'(BAR_SZ_LG[8*n +: 8]));
    localparam logic [63:0] MP = size_mask(int'(KIND_SH[2*n +: 2] == 2'd2 ?
                                               BAR_SZ_LG[8*((n > 0) ? n-1 : 0) +: 8] : 8'd0));
    localparam logic [31:0] WM = UP ? MP[63:32] :
                                 (K == BAR_MEM32 || K == BAR_MEM64) ? (M[31:0] & 32'hFFFF_FFF0) :
                                 (K == BAR_IO) ? (M[31:0] & 32'hFFFF_FFFC) : 32'h0;
    localparam logic [31:0] IV = UP ? 32'h0 :
                                 (K == BAR_MEM64) ? 32'h4 : (K == BAR_IO) ? 32'h1 : 32'h0;
    assign wmask_o[DW_BAR0+n] = WM;
    assign w1c_o[DW_BAR0+n]   = '0;
    assign init_o[DW_BAR0+n]  = IV;
  end

  for (genvar d = 0; d < HDR_DWORDS; d++) begin : g_dw
    if (d < DW_BAR0 || d >= DW_BAR0 + NUM_BAR) begin : g_misc
      always_comb begin
        wmask_o[d] = '0;
        w1c_o[d]   = '0;
        init_o[d]  = '0;
        if (d == 0) begin
          init_o[d] = {DEVICE_ID, VENDOR_ID};
        end else if (d == DW_CMD) begin
          wmask_o[d] = {16'h0, CMD_WMASK};
          w1c_o[d]   = {STS_W1C, 16'h0};
        end else if (d == DW_CLASS) begin
          init_o[d] = {CLASS_CODE, REV_ID};
        end else if (d == DW_HDR) begin
          wmask_o[d] = 32'h0000_FFFF;
        end else if (d == DW_ROM) begin
          wmask_o[d] = ROM_WM;
        end else if (d == DW_INT) begin
          wmask_o[d] = 32'h0000_00FF;
          init_o[d]  = {16'h0, INT_PIN, 8'h00};
        end
      end
    end
  end
endmodule

// File: rtl/cfg_byte_store.sv
module cfg_byte_store
  import cfg_hdr_pkg::*;
#(
  parameter int DWORDS = HDR_DWORDS,
  parameter int AW     = HDR_AW,
  parameter int SET_DW = DW_CMD
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [DWORDS-1:0][31:0] init_i,
  input  logic [DWORDS-1:0][31:0] wmask_i,
  input  logic [DWORDS-1:0][31:0] w1c_i,
  input  logic                   wr_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [3:0]             be_i,
  input  logic [31:0]            wdata_i,
  input  logic [31:0]            set_i,
  output logic [DWORDS-1:0][31:0] dw_o
);
  for (genvar d = 0; d < DWORDS; d++) begin : g_dw
    logic [31:0] q, nxt;
    always_comb begin
      nxt = q;
      if (wr_i && addr_i == AW'(d)) begin
        for (int b = 0; b < 4; b++) begin
          if (be_i[b]) nxt[8*b +: 8] = byte_update(q[8*b +: 8], wdata_i[8*b +: 8],
                                                   wmask_i[d][8*b +: 8], w1c_i[d][8*b +: 8]);
        end
      end
      if (d == SET_DW) nxt = nxt | (set_i & w1c_i[d]);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= init_i[d];
      else         q <= nxt;
    end
    assign dw_o[d] = q;
  end
endmodule

// File: rtl/cfg_bar_decode.sv
module cfg_bar_decode
  import cfg_hdr_pkg::*;
#(
  parameter logic [2*NUM_BAR-1:0] BAR_KIND  = 12'h072,
  parameter int unsigned          ROM_SZ_LG = 18
) (
  input  logic [HDR_DWORDS-1:0][31:0] dw_i,
  output logic [NUM_BAR-1:0]          bar_en_o,
  output logic [NUM_BAR*64-1:0]       bar_base_o,
  output logic                        rom_en_o,
  output logic [31:0]                 rom_base_o
);
  localparam logic [2*NUM_BAR+1:0] KIND_SH = {BAR_KIND, 2'b00};
  logic io_on, mem_on;
  assign io_on  = dw_i[DW_CMD][CMD_IO_BIT];
  assign mem_on = dw_i[DW_CMD][CMD_MEM_BIT];

  for (genvar n = 0; n < NUM_BAR; n++) begin : g_bar
    localparam bar_kind_e K  = bar_kind_e'(BAR_KIND[2*n +: 2]);
    localparam bit        UP = (KIND_SH[2*n +: 2] == 2'd2);
    logic [31:0] lo;
    logic [63:0] base;
    logic        en;
    assign lo = dw_i[DW_BAR0+n];
    if (UP || K == BAR_NONE) begin : g_off
      assign en   = 1'b0;
      assign base = '1;
    end else if (K == BAR_MEM32) begin : g_m32
      assign en   = mem_on;
      assign base = {32'h0, lo[31:4], 4'h0};
    end else if (K == BAR_MEM64) begin : g_m64
      assign en   = mem_on;
      assign base = {dw_i[DW_BAR0+n+1], lo[31:4], 4'h0};
    end else begin : g_io
      assign en   = io_on;
      assign base = {32'h0, lo[31:2], 2'b00};
    end
    assign bar_en_o[n]            = en;
    assign bar_base_o[64*n +: 64] = en ? base : '1;
  end

  assign rom_en_o   = (ROM_SZ_LG != 0) && dw_i[DW_ROM][0] && mem_on;
  assign rom_base_o = rom_en_o ? {dw_i[DW_ROM][31:11], 11'h0} : '1;
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0]          VENDOR_ID  = 16'hA5C3,
  parameter logic [15:0]          DEVICE_ID  = 16'h0F21,
  parameter logic [7:0]           REV_ID     = 8'h02,
  parameter logic [23:0]          CLASS_CODE = 24'h020000,
  parameter logic [7:0]           INT_PIN    = 8'h01,
  parameter logic [2*NUM_BAR-1:0] BAR_KIND   = 12'h072,
  parameter logic [8*NUM_BAR-1:0] BAR_SZ_LG  = 48'h00000E050011,
  parameter int unsigned          ROM_SZ_LG  = 18
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [HDR_AW-1:0]     addr_i,
  input  logic [3:0]            be_i,
  input  logic [31:0]           wdata_i,
  input  logic [15:0]           status_set_i,
  output logic [31:0]           rdata_o,
  output logic                  rvalid_o,
  output logic [NUM_BAR-1:0]    bar_en_o,
  output logic [NUM_BAR*64-1:0] bar_base_o,
  output logic                  rom_en_o,
  output logic [31:0]           rom_base_o,
  output logic                  map_chg_o
);
  localparam int MAP_W = NUM_BAR*64 + NUM_BAR + 33;

  logic [HDR_DWORDS-1:0][31:0] wmask, w1c, init, dw;
  logic [31:0] wr_wmask, wr_w1c;
  logic        wr;
  logic [MAP_W-1:0] map_d, map_q;
  logic        map_vld_q;

  assign wr       = req_i & we_i;
  assign wr_wmask = wmask[addr_i];
  assign wr_w1c   = w1c[addr_i];

  cfg_mask_gen #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID),
    .CLASS_CODE(CLASS_CODE), .INT_PIN(INT_PIN), .BAR_KIND(BAR_KIND),
    .BAR_SZ_LG(BAR_SZ_LG), .ROM_SZ_LG(ROM_SZ_LG)
  ) u_masks (
    .wmask_o(wmask), .w1c_o(w1c), .init_o(init)
  );

  cfg_byte_store #(.DWORDS(HDR_DWORDS), .AW(HDR_AW), .SET_DW(DW_CMD)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init), .wmask_i(wmask), .w1c_i(w1c),
    .wr_i(wr), .addr_i(addr_i), .be_i(be_i), .wdata_i(wdata_i),
    .set_i({status_set_i, 16'h0}), .dw_o(dw)
  );

  cfg_bar_decode #(.BAR_KIND(BAR_KIND), .ROM_SZ_LG(ROM_SZ_LG)) u_dec (
    .dw_i(dw), .bar_en_o(bar_en_o), .bar_base_o(bar_base_o),
    .rom_en_o(rom_en_o), .rom_base_o(rom_base_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i & ~we_i;
      if (req_i && !we_i) rdata_o <= dw[addr_i];
    end
  end

  // decode snapshot; first cycle after reset has no reference
  assign map_d = {bar_base_o, bar_en_o, rom_base_o, rom_en_o};
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q     <= '0;
      map_vld_q <= 1'b0;
    end else begin
      map_q     <= map_d;
      map_vld_q <= 1'b1;
    end
  end
  assign map_chg_o = map_vld_q && (map_d != map_q);
endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID = 16'h0F21
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [HDR_AW-1:0]     addr_i,
  input logic [31:0]           rdata_o,
  input logic                  rvalid_o,
  input logic [NUM_BAR-1:0]    bar_en_o,
  input logic [NUM_BAR*64-1:0] bar_base_o,
  input logic                  rom_en_o,
  input logic [31:0]           rom_base_o,
  input logic                  map_chg_o,
  input logic [31:0]           wr_wmask,
  input logic [31:0]           wr_w1c
);
  assert_mask_disjoint_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |-> ((wr_wmask & wr_w1c) == 32'h0));

  assert_read_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  assert_rvalid_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));

  assert_id_fixed_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(addr_i) == '0) |-> (rdata_o == {DEVICE_ID, VENDOR_ID}));

  for (genvar n = 0; n < NUM_BAR; n++) begin : g_unm
    assert_unmapped_ones_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bar_en_o[n] |-> (bar_base_o[64*n +: 64] == '1));
  end

  assert_rom_unmapped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_en_o |-> (rom_base_o == '1));

  assert_chg_after_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_chg_o |-> $past(req_i && we_i));

  assert_chg_real_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_chg_o |-> !$stable({bar_base_o, bar_en_o, rom_base_o, rom_en_o}));
endmodule

bind cfg_hdr_regs cfg_hdr_chk #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o), .bar_en_o(bar_en_o), .bar_base_o(bar_base_o),
  .rom_en_o(rom_en_o), .rom_base_o(rom_base_o), .map_chg_o(map_chg_o),
  .wr_wmask(wr_wmask), .wr_w1c(wr_w1c)
);

// File: tb/cfg_hdr_regs_bench.sv
module cfg_hdr_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic [15:0] sset = '0;
  logic [31:0] rdata;
  logic rvalid;
  logic [5:0] bar_en;
  logic [383:0] bar_base;
  logic rom_en;
  logic [31:0] rom_base;
  logic map_chg;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  cfg_hdr_regs u_cfg_hdr_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .be_i(be),
    .wdata_i(wdata), .status_set_i(sset), .rdata_o(rdata), .rvalid_o(rvalid),
    .bar_en_o(bar_en), .bar_base_o(bar_base), .rom_en_o(rom_en), .rom_base_o(rom_base),
    .map_chg_o(map_chg)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (sb_q.size() == 0) begin
        chk("R2 unexpected rvalid", 64'(rvalid), 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, 64'(rdata), 64'(e.exp));
      end
    end
  end

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    sb_q.push_back('{e, tag});
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 6'(a);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wr(input int a, input logic [3:0] b, input logic [31:0] d,
                    input logic exp_chg, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 6'(a); be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk({tag, " R11 chg"}, 64'(map_chg), 64'(exp_chg));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bar_en", 64'(bar_en), 64'd0);
    chk("R9 bar0 base", bar_base[63:0], '1);
    chk("R9 bar3 base", bar_base[255:192], '1);
    chk("R1 rom_en", 64'(rom_en), 64'd0);
    rd(0, 32'h0F21_A5C3, "R1 id");
    rd(1, 32'h0, "R1 cmd");
    rd(2, 32'h0200_0002, "R1 class");
    rd(3, 32'h0, "R1 hdr");
    rd(4, 32'h4, "R6 bar0 mem64 type");
    rd(5, 32'h0, "R1 bar1");
    rd(6, 32'h1, "R6 bar2 io type");
    rd(7, 32'h0, "R6 bar3 mem32 type");
    rd(15, 32'h0000_0100, "R1 int pin");

    // R3 byte enables and command mask
    wr(1, 4'b0010, 32'h0000_FF00, 1'b0, "R3 cmd hi");
    rd(1, 32'h0000_0500, "R3 cmd hi");
    wr(1, 4'b0001, 32'h0000_00FF, 1'b1, "R3 cmd lo");
    rd(1, 32'h0000_0547, "R3 cmd lo");
    wr(1, 4'b0011, 32'h0, 1'b1, "R3 cmd clr");

    // R5 size probe with decode off
    for (int i = 4; i < 10; i++) wr(i, 4'hF, 32'hFFFF_FFFF, 1'b0, "R5 probe");
    wr(12, 4'hF, 32'hFFFF_FFFF, 1'b0, "R5 rom probe");
    rd(4, 32'hFFFE_0004, "R5 bar0");
    rd(5, 32'hFFFF_FFFF, "R5 bar0 upper");
    rd(6, 32'hFFFF_FFE1, "R5 bar2 io");
    rd(7, 32'hFFFF_C000, "R5 bar3");
    rd(8, 32'h0, "R5 bar4 absent");
    rd(12, 32'hFFFC_0001, "R10 rom probe");

    // program
    wr(4, 4'hF, 32'hFEB8_0000, 1'b0, "R5 prog0");
    wr(5, 4'hF, 32'h0, 1'b0, "R5 prog1");
    wr(6, 4'hF, 32'h0000_C000, 1'b0, "R5 prog2");
    wr(7, 4'hF, 32'hFEBD_1234, 1'b0, "R5 prog3");
    wr(12, 4'hF, 32'hFEB4_0001, 1'b0, "R10 prog rom");
    rd(4, 32'hFEB8_0004, "R5 bar0 rb");
    rd(6, 32'h0000_C001, "R5 bar2 rb");
    rd(7, 32'hFEBD_0000, "R5 bar3 low bits");

    // R7 memory on
    wr(1, 4'b0011, 32'h0000_0002, 1'b1, "R7 mem on");
    chk("R7 en", 64'(bar_en), 64'b001001);
    chk("R7 base0", bar_base[63:0], 64'h0000_0000_FEB8_0000);
    chk("R7 base3", bar_base[255:192], 64'h0000_0000_FEBD_0000);
    chk("R9 io off", bar_base[191:128], '1);
    chk("R9 upper half", bar_base[127:64], '1);
    chk("R10 rom en", 64'(rom_en), 64'd1);
    chk("R10 rom base", 64'(rom_base), 64'hFEB4_0000);

    // R8 io on
    wr(1, 4'b0011, 32'h0000_0003, 1'b1, "R8 io on");
    chk("R8 en", 64'(bar_en), 64'b001101);
    chk("R8 base2", bar_base[191:128], 64'h0000_0000_0000_C000);

    // R7 64-bit upper
    wr(5, 4'hF, 32'h1, 1'b1, "R7 upper");
    chk("R7 base0 64", bar_base[63:0], 64'h0000_0001_FEB8_0000);
    wr(5, 4'hF, 32'h1, 1'b0, "R11 same value");

    // R4 w1c status
    @(negedge clk); sset = 16'hFFFF;
    @(negedge clk); sset = 16'h0;
    rd(1, 32'hF900_0003, "R4 set");
    wr(1, 4'hF, 32'h0800_0003, 1'b0, "R4 clear one");
    rd(1, 32'hF100_0003, "R4 clear one");
    wr(1, 4'b0011, 32'hFFFF_0003, 1'b0, "R3 status be off");
    rd(1, 32'hF100_0003, "R3 status be off");

    // R10 rom enable / reserved
    wr(12, 4'hF, 32'hFEB4_0000, 1'b1, "R10 rom off");
    chk("R10 rom off en", 64'(rom_en), 64'd0);
    chk("R9 rom base", 64'(rom_base), 64'hFFFF_FFFF);
    wr(12, 4'hF, 32'hFEB4_07FE, 1'b0, "R10 reserved");
    rd(12, 32'hFEB4_0000, "R10 reserved");

    // R12 read-only identification
    wr(0, 4'hF, 32'hFFFF_FFFF, 1'b0, "R12 id");
    rd(0, 32'h0F21_A5C3, "R12 id");
    wr(2, 4'hF, 32'hFFFF_FFFF, 1'b0, "R12 class");
    rd(2, 32'h0200_0002, "R12 class");
    wr(3, 4'hF, 32'hFFFF_FFFF, 1'b0, "R12 hdr type");
    rd(3, 32'h0000_FFFF, "R12 hdr type");
    wr(15, 4'hF, 32'hFFFF_FFFF, 1'b0, "R3 int line");
    rd(15, 32'h0000_01FF, "R3 int line");

    // R8 io off with mem on
    wr(1, 4'b0011, 32'h0000_0002, 1'b1, "R8 io off");
    chk("R8 en io off", 64'(bar_en), 64'b001001);
    chk("R9 io base off", bar_base[191:128], '1);

    repeat (4) @(negedge clk);
    chk("R2 queue drained", 64'(sb_q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule